// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable model of a synchronous static RAM that accepts a new read or write command on every clock edge. It needs no idle cycle when the bus changes direction. Address, command and byte-lane enables are sampled on the rising clock edge. Write data is deliberately delayed so that it uses the same bus slot as read data would. A write issued on edge n therefore takes its data on the same later edge at which a read issued on edge n would present its result. As a result, any mix of reads and writes keeps the data bus fully busy.

A static mode input selects the depth of the data path:

- **Registered mode:** results pass through an output register. Both reads and writes trail their command by two enabled edges.
- **Flow-through mode:** the output register is bypassed. Both reads and writes trail by one enabled edge.

The block also provides:

- an internal burst counter, with linear or interleaved stepping of the two low address bits;
- a global clock enable;
- 9-bit byte-lane write masking;
- triple chip select;
- an asynchronous output enable;
- a sleep input that stops the block after a fixed delay without losing its contents.

In registered mode, a read can follow its own address's write by a single cycle. The pending write data is then forwarded into the read result lane by lane.

Top module: `zeroturn_sram`

## Requirements
- R1: While reset is held and after it is released, `driveEn` is low and `dataOut` is zero until a read result is due.
- R2: With `flowMode` low, a read accepted on enabled edge n shows its word on `dataOut` with `driveEn` high from edge n+2 until the next enabled edge.
- R3: With `flowMode` low, a write accepted on enabled edge n takes `dataIn` at enabled edge n+2. Reads and writes may alternate on consecutive edges with no idle slot.
- R4: With `flowMode` high, read results appear after edge n+1 and write data is taken at edge n+1.
- R5: `byteEn[0]` guards bits 8:0 and `byteEn[1]` guards bits 17:9. Unselected lanes keep their old contents. A write with `byteEn` of zero changes nothing.
- R6: In registered mode, a read issued one edge after a write to the same address returns the write's data in the enabled lanes and the stored data in the others.
- R7: With `advance` high, the next address is formed from the last loaded address. The upper bits are kept, and the low two bits become base+k modulo 4 when `interleave` is low, or base XOR k when `interleave` is high (k = 1, 2, 3, then wrapping). The command kind of the last load is reused and `chipSel`/`writeCmd` are ignored. After a deselected load, an advance does nothing.
- R8: A load with `advance` low is a read or write only when all three `chipSel` bits are high. Otherwise it is a no-operation.
- R9: An edge with `clkEn` low is ignored: no command, no write, no pipeline step, and `dataOut` holds.
- R10: `driveEn` is high only in a read result slot and only while `outEn` is high. Write slots never drive. `dataOut` is zero whenever `driveEn` is low.
- R11: When `sleep` has been high on the two previous edges, the block is asleep: commands are ignored, `driveEn` stays low, and the stored contents are kept for use after waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Edge qualifier; low means the edge is ignored |
| chipSel | input | 3 | All bits high select the block on a load |
| advance | input | 1 | 1 = step burst counter, 0 = load new address |
| writeCmd | input | 1 | 1 = write, 0 = read on a load |
| byteEn | input | 2 | Per-lane write enables |
| addr | input | 8 | Word address for a load |
| dataIn | input | 18 | Late write data |
| outEn | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Power-down request |
| flowMode | input | 1 | 1 = flow-through, 0 = registered |
| interleave | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| dataOut | output | 18 | Read result |
| driveEn | output | 1 | High when `dataOut` carries a read result |

## Verification
The assertions take `flowMode` and `interleave` as static during traffic. They also assume that `clkEn`, `outEn` and `sleep` change only away from the clock edge. The stimulus meets these conditions by changing mode inputs only after several no-operation cycles, with no command in flight. All inputs are driven a fixed delay after the falling edge. The sleep sequence also lets in-flight writes finish before the stored word is read back after waking.

// File: rtl/zts_pkg.sv
package zts_pkg;
  parameter int ADDR_W    = 8;
  parameter int BYTE_W    = 9;
  parameter int NUM_BYTES = 2;
  parameter int BURST_W   = 2;
  localparam int DATA_W   = BYTE_W * NUM_BYTES;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKindT;

  // One accepted command travelling down the late-write pipeline
  typedef struct packed {
    opKindT                kind;
    logic [ADDR_W-1:0]     addr;
    logic [NUM_BYTES-1:0]  lanes;
  } slotT;

  // Strobes from control to datapath
  typedef struct packed {
    logic                  wrEn;
    logic [ADDR_W-1:0]     wrAddr;
    logic [NUM_BYTES-1:0]  wrLanes;
    logic [ADDR_W-1:0]     rdAddr;
    logic                  rdLoad;
    logic [NUM_BYTES-1:0]  fwdLanes;
    logic                  useFlow;
    logic                  driveOk;
  } strobeT;
endpackage

// File: rtl/zts_ctrl.sv
module zts_ctrl
  import zts_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEn,
  input  logic [2:0]           chipSel,
  input  logic                 advance,
  input  logic                 writeCmd,
  input  logic [NUM_BYTES-1:0] byteEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 outEn,
  input  logic                 sleep,
  input  logic                 flowMode,
  input  logic                 interleave,
  output strobeT               strobe,
  output logic                 asleep
);
  logic [1:0]          sleepQ;
  opKindT              lastKind;
  logic [ADDR_W-1:0]   burstBase;
  logic [BURST_W-1:0]  burstCnt, cntNext, seqLow;
  slotT                st1, st2, newSlot, wrSrc;
  logic                outValid, loadCmd, stepCmd, selected;
  opKindT              loadKind;

  assign asleep   = sleepQ[1];
  assign selected = &chipSel;
  assign loadCmd  = !asleep && !advance;
  assign stepCmd  = !asleep && advance && (lastKind != OP_IDLE);
  assign cntNext  = burstCnt + 1'b1;
  assign loadKind = !selected ? OP_IDLE : (writeCmd ? OP_WRITE : OP_READ);

  // Low address bits of the next burst beat
  always_comb begin
    if (interleave) seqLow = burstBase[BURST_W-1:0] ^ cntNext;
    else            seqLow = burstBase[BURST_W-1:0] + cntNext;
  end

  always_comb begin
    newSlot.kind  = OP_IDLE;
    newSlot.addr  = addr;
    newSlot.lanes = byteEn;
    if (loadCmd) begin
      newSlot.kind = loadKind;
    end else if (stepCmd) begin
      newSlot.kind = lastKind;
      newSlot.addr = {burstBase[ADDR_W-1:BURST_W], seqLow};
    end
  end

  // Sleep request settles after two edges, independent of clkEn
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sleepQ <= '0;
    else       sleepQ <= {sleepQ[0], sleep};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastKind  <= OP_IDLE;
      burstBase <= '0;
      burstCnt  <= '0;
      st1       <= '0;
      st2       <= '0;
      outValid  <= 1'b0;
    end else if (clkEn) begin
      if (loadCmd) begin
        burstBase <= addr;
        burstCnt  <= '0;
        lastKind  <= loadKind;
      end else if (stepCmd) begin
        burstCnt  <= cntNext;
      end
      st1      <= newSlot;
      st2      <= st1;
      outValid <= !flowMode && (st1.kind == OP_READ);
    end
  end

  // Write commits from the slot whose data is on the bus now
  assign wrSrc = flowMode ? st1 : st2;

  always_comb begin
    strobe.wrEn     = clkEn && (wrSrc.kind == OP_WRITE);
    strobe.wrAddr   = wrSrc.addr;
    strobe.wrLanes  = wrSrc.lanes;
    strobe.rdAddr   = st1.addr;
    strobe.rdLoad   = clkEn && !flowMode && (st1.kind == OP_READ);
    strobe.fwdLanes = (!flowMode && st2.kind == OP_WRITE && st2.addr == st1.addr)
                      ? st2.lanes : '0;
    strobe.useFlow  = flowMode;
    strobe.driveOk  = outEn && !asleep &&
                      (flowMode ? (st1.kind == OP_READ) : outValid);
  end
endmodule

// File: rtl/zts_datapath.sv
module zts_datapath
  import zts_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] arrWord, merged, outReg;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : gLane
    logic [BYTE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.wrEn && strobe.wrLanes[g])
        store[strobe.wrAddr] <= dataIn[g*BYTE_W +: BYTE_W];
    end

    assign arrWord[g*BYTE_W +: BYTE_W] = store[strobe.rdAddr];
    // Pending late-write lane overrides the stale array lane
    assign merged[g*BYTE_W +: BYTE_W]  = strobe.fwdLanes[g]
                                         ? dataIn[g*BYTE_W +: BYTE_W]
                                         : arrWord[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              outReg <= '0;
    else if (strobe.rdLoad) outReg <= merged;
  end

  assign dataOut = !strobe.driveOk ? '0 : (strobe.useFlow ? arrWord : outReg);
endmodule

// File: rtl/zeroturn_sram.sv
module zeroturn_sram
  import zts_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEn,
  input  logic [2:0]           chipSel,
  input  logic                 advance,
  input  logic                 writeCmd,
  input  logic [NUM_BYTES-1:0] byteEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic                 outEn,
  input  logic                 sleep,
  input  logic                 flowMode,
  input  logic                 interleave,
  output logic [DATA_W-1:0]    dataOut,
  output logic                 driveEn
);
  strobeT strobe;
  logic   asleep;

  zts_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .chipSel(chipSel),
    .advance(advance), .writeCmd(writeCmd), .byteEn(byteEn), .addr(addr),
    .outEn(outEn), .sleep(sleep), .flowMode(flowMode),
    .interleave(interleave), .strobe(strobe), .asleep(asleep)
  );

  zts_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn), .dataOut(dataOut)
  );

  assign driveEn = strobe.driveOk;
endmodule

// File: rtl/zts_checker.sv
module zts_checker
  import zts_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic [2:0]        chipSel,
  input logic              advance,
  input logic              writeCmd,
  input logic              outEn,
  input logic              sleep,
  input logic              flowMode,
  input logic              asleep,
  input logic              driveEn,
  input logic [DATA_W-1:0] dataOut
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !driveEn);

  assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |-> (dataOut == '0));

  assert_write_slot_R10: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode && sinceRst != 2'd0 &&
     $past(clkEn && (&chipSel) && !advance && writeCmd && !asleep)) |-> !driveEn);

  assert_sleep_delay_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (asleep == $past(sleep, 2)));

  assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    asleep |-> !driveEn);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!flowMode && sinceRst != 2'd0 && !$past(clkEn) && $past(driveEn) && driveEn)
    |-> $stable(dataOut));
endmodule

bind zeroturn_sram zts_checker u_chk (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .chipSel(chipSel),
  .advance(advance), .writeCmd(writeCmd), .outEn(outEn), .sleep(sleep),
  .flowMode(flowMode), .asleep(asleep), .driveEn(driveEn), .dataOut(dataOut)
);

// File: tb/sim_zeroturn_sram.sv
`timescale 1ns/100ps
module sim_zeroturn_sram;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b1;
  logic [2:0]  chipSel = 3'b000;
  logic        advance = 1'b0;
  logic        writeCmd = 1'b0;
  logic [1:0]  byteEn = 2'b00;
  logic [7:0]  addr = 8'h00;
  logic [17:0] dataIn = 18'h0;
  logic        outEn = 1'b1;
  logic        sleep = 1'b0;
  logic        flowMode = 1'b0;
  logic        interleave = 1'b0;
  logic [17:0] dataOut;
  logic        driveEn;

  int    checks = 0;
  int    fails = 0;
  bit    started = 0;
  bit    finished = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  zeroturn_sram u0 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .chipSel(chipSel),
    .advance(advance), .writeCmd(writeCmd), .byteEn(byteEn), .addr(addr),
    .dataIn(dataIn), .outEn(outEn), .sleep(sleep), .flowMode(flowMode),
    .interleave(interleave), .dataOut(dataOut), .driveEn(driveEn)
  );

  // ---------------- behavioural reference ----------------
  logic [17:0] mm [256];
  bit   [1:0]  kn [256];
  int          h1k = 0, h1a = 0, h2k = 0, h2a = 0;
  logic [1:0]  h1b = 0, h2b = 0;
  int          lastK = 0, cntM = 0, baseM = 0;
  bit          sq0 = 0, sq1 = 0, rdV = 0, rdK = 0;
  logic [17:0] rdD = 0;
  int          wk, wa, nk, na, lo;
  logic [1:0]  wb;

  initial for (int i = 0; i < 256; i++) kn[i] = 2'b00;

  always @(posedge clk) begin
    started = 1;
    if (!rstN) begin
      h1k = 0; h2k = 0; lastK = 0; cntM = 0; baseM = 0;
      sq0 = 0; sq1 = 0; rdV = 0;
    end else begin
      if (clkEn) begin
        if (flowMode) begin wk = h1k; wa = h1a; wb = h1b; end
        else          begin wk = h2k; wa = h2a; wb = h2b; end
        if (wk == 2)
          for (int l = 0; l < 2; l++)
            if (wb[l]) begin
              mm[wa][l*9 +: 9] = dataIn[l*9 +: 9];
              kn[wa][l] = 1'b1;
            end
        rdV = !flowMode && (h1k == 1);
        if (rdV) begin rdD = mm[h1a]; rdK = &kn[h1a]; end
        nk = 0; na = addr;
        if (!sq1) begin
          if (!advance) begin
            baseM = addr; cntM = 0;
            lastK = (chipSel == 3'b111) ? (writeCmd ? 2 : 1) : 0;
            nk = lastK;
          end else if (lastK != 0) begin
            cntM = (cntM + 1) % 4;
            lo = interleave ? ((baseM & 3) ^ cntM) : (((baseM & 3) + cntM) & 3);
            na = (baseM & 252) | lo;
            nk = lastK;
          end
        end
        h2k = h1k; h2a = h1a; h2b = h1b;
        h1k = nk;  h1a = na;  h1b = byteEn;
      end
      sq1 = sq0; sq0 = sleep;
    end
  end

  // ---------------- comparison on every clock ----------------
  bit          expDrv, expK;
  logic [17:0] expD;
  always @(negedge clk) begin
    if (started && !finished) begin
      expDrv = outEn && !sq1 && (flowMode ? (h1k == 1) : rdV);
      expD   = flowMode ? mm[h1a] : rdD;
      expK   = flowMode ? (&kn[h1a]) : rdK;
      checks++;
      if (driveEn !== expDrv) begin
        fails++;
        $display("FAIL %s: driveEn=%0b expected %0b at %0t", tag, driveEn, expDrv, $time);
      end
      if (expDrv && expK) begin
        checks++;
        if (dataOut !== expD) begin
          fails++;
          $display("FAIL %s: dataOut=%h expected %h at %0t", tag, dataOut, expD, $time);
        end
      end else if (!expDrv) begin
        checks++;
        if (dataOut !== 18'h0) begin
          fails++;
          $display("FAIL R10 (%s): idle dataOut=%h expected 0 at %0t", tag, dataOut, $time);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  logic [17:0] pd1 = 18'h0, pd2 = 18'h0;
  int          stepNo = 0;

  task automatic step(input bit ce, input bit [2:0] cs, input bit adv, input bit wr,
                      input bit [1:0] be, input bit [7:0] a, input bit [17:0] wd);
    @(negedge clk); #1;
    stepNo++;
    clkEn = ce; chipSel = cs; advance = adv; writeCmd = wr; byteEn = be; addr = a;
    if (ce) begin
      dataIn = flowMode ? pd1 : pd2;
      pd2 = pd1;
      pd1 = wd;
    end else begin
      dataIn = 18'h2AAAA ^ 18'(stepNo);
    end
  endtask

  function automatic logic [17:0] junk();
    return 18'h15A5A ^ 18'(stepNo * 37);
  endfunction

  task automatic wrc(input bit [7:0] a, input bit [17:0] d, input bit [1:0] be = 2'b11);
    step(1, 3'b111, 0, 1, be, a, d);
  endtask
  task automatic rdc(input bit [7:0] a);
    step(1, 3'b111, 0, 0, 2'b00, a, junk());
  endtask
  task automatic nop(input int n = 1);
    for (int i = 0; i < n; i++) step(1, 3'b000, 0, 0, 2'b00, 8'hEE, junk());
  endtask
  task automatic adv(input bit [17:0] d);
    step(1, 3'b000, 1, 0, 2'b11, 8'hFF, d);
  endtask
  task automatic stall();
    step(0, 3'b111, 0, 1, 2'b11, 8'h10, junk());
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    nop(2);

    tag = "R2";                      // registered read latency
    wrc(8'h10, 18'h00A01); wrc(8'h11, 18'h1B2C3); nop(2);
    rdc(8'h10); rdc(8'h11); nop(3);

    tag = "R3";                      // alternating read/write, no gaps
    wrc(8'h12, 18'h3C0DE); rdc(8'h10); wrc(8'h13, 18'h2F00F);
    rdc(8'h12); rdc(8'h13); wrc(8'h10, 18'h12345); rdc(8'h11); rdc(8'h10); nop(3);

    tag = "R6";                      // forwarding of a pending write
    wrc(8'h20, 18'h0BEEF); rdc(8'h20);
    wrc(8'h20, 18'h3FE01, 2'b01); rdc(8'h20);
    wrc(8'h20, 18'h155AA, 2'b10); rdc(8'h20); nop(3);

    tag = "R5";                      // lane masks and write abort
    wrc(8'h21, 18'h11111); wrc(8'h21, 18'h3FFFF, 2'b10); nop(2); rdc(8'h21);
    wrc(8'h21, 18'h00000, 2'b00); nop(2); rdc(8'h21); nop(3);

    tag = "R8";                      // partial chip select is a no-op
    step(1, 3'b011, 0, 1, 2'b11, 8'h10, 18'h0DEAD);
    step(1, 3'b110, 0, 1, 2'b11, 8'h10, 18'h0FACE);
    step(1, 3'b101, 0, 0, 2'b00, 8'h10, junk());
    nop(1); rdc(8'h10); nop(3);

    tag = "R7";                      // bursts
    wrc(8'h12, 18'h10000); adv(18'h10001); adv(18'h10002); adv(18'h10003); nop(3);
    rdc(8'h12); adv(junk()); adv(junk()); adv(junk()); nop(1);
    rdc(8'h13); adv(junk()); adv(junk()); adv(junk()); adv(junk()); nop(1);
    interleave = 1'b1;
    rdc(8'h13); adv(junk()); adv(junk()); adv(junk()); nop(1);
    wrc(8'h31, 18'h20000); adv(18'h20001); adv(18'h20002); adv(18'h20003); nop(3);
    rdc(8'h30); adv(junk()); adv(junk()); adv(junk()); nop(1);
    step(1, 3'b001, 0, 0, 2'b00, 8'h30, junk()); adv(junk()); adv(junk()); nop(3);
    interleave = 1'b0;

    tag = "R9";                      // clock-enable stalls
    rdc(8'h10); stall(); stall(); rdc(8'h11); stall(); nop(1);
    wrc(8'h14, 18'h07777); stall(); stall(); nop(1); stall(); nop(1); rdc(8'h14); stall(); nop(3);

    tag = "R10";                     // output enable and write slots
    rdc(8'h10); rdc(8'h11); outEn = 1'b0; rdc(8'h12); nop(1); outEn = 1'b1;
    rdc(8'h13); wrc(8'h15, 18'h03030); rdc(8'h13); nop(3);

    tag = "R11";                     // sleep
    nop(2); sleep = 1'b1; nop(3);
    wrc(8'h10, 18'h3ABCD); wrc(8'h10, 18'h3ABCD); rdc(8'h10); nop(2);
    sleep = 1'b0; nop(3); rdc(8'h10); nop(3);

    tag = "R4";                      // flow-through
    flowMode = 1'b1; nop(3);
    wrc(8'h40, 18'h04040); rdc(8'h40); wrc(8'h41, 18'h14141); rdc(8'h40); rdc(8'h41);
    wrc(8'h40, 18'h3F0F0, 2'b01); rdc(8'h40); stall(); rdc(8'h41); nop(1);
    rdc(8'h12); adv(junk()); adv(junk()); adv(junk()); nop(1);
    outEn = 1'b0; rdc(8'h40); outEn = 1'b1; nop(3);
    flowMode = 1'b0; nop(3);
    rdc(8'h40); rdc(8'h41); nop(4);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog (%s): run did not complete, expected completion", tag);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule